// File: doc/BRIEF.md
# Speculation-Aware MESI Line Controller

This block runs the first-level coherence state of one cache line in a two-level MESI directory system. It adds two request kinds beside ordinary loads and stores. A speculative load may fetch data for the core without installing the line and without touching coherence state. An expose request later turns such an access into an ordinary visible shared read. The core drives one request port. The network side takes forwarded requests and invalidations from the L2, plus data and writeback-acknowledge responses. The block sends requests toward the L2 bank, and data or acknowledgement messages to a requester or to the L2. It reports completions and evictions back to the core.

The line's contents are one opaque data register. A single transaction buffer holds the core's index tag, store data or the writeback copy while the line is in a transient state. Core requests that arrive during a transient state wait on `core_req_ready`. Forwarded requests wait on `fwd_ready` while an outgoing message is still being delivered.

Top module: `spec_l1_line_ctrl`

## Requirements
- R1: After reset the line is in the not-present state and no buffer entry is held. `core_req_ready` is high and `fwd_ready` is high. `done_valid`, `evict_valid`, `nreq_valid` and `out_valid` are low.
- R2: A speculative load (op 2) in not-present or invalid issues a request of type GETSPEC (2) carrying the core index. It holds only a buffer entry and enters the speculative-wait state.
- R3: In the speculative-wait state, a DATA (kind 0) or peer-shared DATA (kind 2) response completes the request to the core with the buffered index and the response data. The line then returns to invalid with nothing installed, so a following load misses. Exclusive data (kind 1) never arrives in that state.
- R4: An invalidation (fwd type 0) in not-present, invalid or speculative-wait is answered by one ACK (kind 1) to the requester (dest 0). It changes no state and reports no eviction.
- R5: A speculative load that hits in S, E or M completes at once with the line data. It issues no request and leaves the state unchanged.
- R6: An expose (op 3) that misses issues type EXPOSE (3) and follows the ordinary shared-fill path. An expose hit in S, E or M completes like a load hit.
- R7: A forwarded speculative get (fwd type 3) in E or M sends DATA (kind 0) to the requester with dirty set only in M, and keeps the state. During a writeback it answers from the buffered copy.
- R8: A forwarded expose (fwd type 4) in E or M sends DATA first to the requester (dest 0) and then to the L2 (dest 1), and the line moves to S. During a writeback both copies come from the buffer and the line waits only for the writeback acknowledge.
- R9: Every core request is held off (`core_req_ready` low) while the line is in any transient state.
- R10: An eviction caused by an invalidation or a forwarded exclusive get is reported with `evict_ext` high. A local replacement (op 4) reports `evict_ext` low.
- R11: Load (op 0) and store (op 1) follow MESI. A miss issues GETS (0) or GETX (1). A store in S issues GETX. A store hit in E or M completes silently with the store data and leaves M. Replacing M issues PUTX (4) with the line data and waits for the writeback acknowledge (kind 3).
- R12: `nreq_valid` and `out_valid` stay asserted, with stable fields, until their ready inputs accept them.
- R13: An invalidation during a shared fill is acknowledged. The fill data is still delivered once to the core, and the line ends invalid.
- R14: A forwarded GETS (fwd type 1) behaves like a forwarded expose. A forwarded GETX (fwd type 2) in E or M sends DATA to the requester and invalidates the line. An invalidation in M returns dirty DATA to the L2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Core request accepted this cycle |
| core_req_op | input | 3 | 0 load, 1 store, 2 speculative load, 3 expose, 4 replacement |
| core_req_idx | input | IDX_W | Core tag echoed on completion |
| core_req_wdata | input | DATA_W | Store data (whole block) |
| done_valid | output | 1 | One-cycle completion pulse |
| done_idx | output | IDX_W | Index tag of the completed request |
| done_data | output | DATA_W | Data returned or stored |
| evict_valid | output | 1 | One-cycle eviction report |
| evict_ext | output | 1 | Eviction came from outside |
| nreq_valid | output | 1 | Request toward the L2 |
| nreq_ready | input | 1 | Request accepted |
| nreq_type | output | 3 | 0 GETS, 1 GETX, 2 GETSPEC, 3 EXPOSE, 4 PUTX |
| nreq_idx | output | IDX_W | Core index tag |
| nreq_data | output | DATA_W | Writeback data for PUTX, zero otherwise |
| fwd_valid | input | 1 | Forwarded request or invalidation |
| fwd_ready | output | 1 | Forwarded request accepted |
| fwd_type | input | 3 | 0 INV, 1 GETS, 2 GETX, 3 GETSPEC, 4 EXPOSE |
| rsp_valid | input | 1 | Response from the network |
| rsp_kind | input | 2 | 0 DATA, 1 exclusive DATA, 2 peer-shared DATA, 3 writeback ack |
| rsp_data | input | DATA_W | Response data |
| out_valid | output | 1 | Outgoing response message |
| out_ready | input | 1 | Outgoing message accepted |
| out_dest | output | 1 | 0 requester, 1 L2 |
| out_kind | output | 1 | 0 DATA, 1 ACK |
| out_dirty | output | 1 | Data is dirty |
| out_data | output | DATA_W | Data payload, zero for ACK |

## Verification
The bench builds the block with a 16-bit data block and a 3-bit index. Every index value, including the largest, can then appear in requests and completions, and each data pattern can be told apart at a glance. The small widths let one directed sequence visit each stable and transient state and every forwarded type in each state that accepts it. The sequence also holds the two ready inputs low for several cycles, which exposes the two-message sequence of a forwarded expose or GETS under back-pressure.

// File: rtl/spec_l1_pkg.sv
package spec_l1_pkg;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_SPEC   = 3'd2,
        OP_EXPOSE = 3'd3,
        OP_REPL   = 3'd4
    } core_op_e;

    typedef enum logic [2:0] {
        NQ_GETS    = 3'd0,
        NQ_GETX    = 3'd1,
        NQ_GETSPEC = 3'd2,
        NQ_EXPOSE  = 3'd3,
        NQ_PUTX    = 3'd4
    } nreq_type_e;

    typedef enum logic [2:0] {
        FW_INV    = 3'd0,
        FW_GETS   = 3'd1,
        FW_GETX   = 3'd2,
        FW_GETSPC = 3'd3,
        FW_EXPOSE = 3'd4
    } fwd_type_e;

    typedef enum logic [1:0] {
        RK_DATA   = 2'd0,
        RK_EXCL   = 2'd1,
        RK_PEER   = 2'd2,
        RK_WBACK  = 2'd3
    } rsp_kind_e;

    localparam logic OUT_DATA = 1'b0;
    localparam logic OUT_ACK  = 1'b1;
    localparam logic DST_REQ  = 1'b0;
    localparam logic DST_L2   = 1'b1;

    typedef enum logic [3:0] {
        LS_NP, LS_I, LS_S, LS_E, LS_M,
        LS_IS, LS_IM, LS_IX, LS_IS_I, LS_SM, LS_MI, LS_SINK
    } line_state_e;

    function automatic logic is_transient(line_state_e s);
        return (s == LS_IS) || (s == LS_IM) || (s == LS_IX) || (s == LS_IS_I) ||
               (s == LS_SM) || (s == LS_MI) || (s == LS_SINK);
    endfunction

endpackage

// File: rtl/spec_l1_tbuf.sv
module spec_l1_tbuf #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic              free,
    output logic              tb_valid,
    output logic [IDX_W-1:0]  tb_idx,
    output logic [DATA_W-1:0] tb_data
);
    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } tbuf_t;

    tbuf_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (free) r_d.valid = 1'b0;
        if (alloc) begin
            r_d.valid = 1'b1;
            r_d.idx   = alloc_idx;
            r_d.data  = alloc_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tb_valid = r_q.valid;
    assign tb_idx   = r_q.idx;
    assign tb_data  = r_q.data;

    // R2: one outstanding transaction per line
    p_single_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !r_q.valid);
    // R3: freeing only what exists
    p_free_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        free |-> r_q.valid);
endmodule

// File: rtl/spec_l1_rsp_out.sv
module spec_l1_rsp_out #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              push_req,
    input  logic              push_l2,
    input  logic              push_kind,
    input  logic              push_dirty,
    input  logic [DATA_W-1:0] push_data,
    output logic              busy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_dest,
    output logic              out_kind,
    output logic              out_dirty,
    output logic [DATA_W-1:0] out_data
);
    import spec_l1_pkg::*;

    typedef struct packed {
        logic              to_req;
        logic              to_l2;
        logic              kind;
        logic              dirty;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (out_valid && out_ready) begin
            if (r_q.to_req) r_d.to_req = 1'b0;
            else            r_d.to_l2  = 1'b0;
        end
        if (push) begin
            r_d.to_req = push_req;
            r_d.to_l2  = push_l2;
            r_d.kind   = push_kind;
            r_d.dirty  = push_dirty;
            r_d.data   = push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid = r_q.to_req | r_q.to_l2;
    assign busy      = out_valid;
    assign out_dest  = r_q.to_req ? DST_REQ : DST_L2;
    assign out_kind  = r_q.kind;
    assign out_dirty = r_q.dirty;
    assign out_data  = r_q.data;

    // R12: message held until taken
    p_out_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dest) && $stable(out_data)));
    // R8: requester copy is delivered before the L2 copy
    p_req_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.to_req && r_q.to_l2 && out_ready) |=> (out_valid && out_dest == DST_L2));
    // R12: a new message never overwrites a pending one
    p_no_overwrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !busy);
endmodule

// File: rtl/spec_l1_fsm.sv
module spec_l1_fsm #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req_valid,
    output logic              core_req_ready,
    input  logic [2:0]        core_req_op,
    input  logic [IDX_W-1:0]  core_req_idx,
    input  logic [DATA_W-1:0] core_req_wdata,
    output logic              done_valid,
    output logic [IDX_W-1:0]  done_idx,
    output logic [DATA_W-1:0] done_data,
    output logic              evict_valid,
    output logic              evict_ext,
    output logic              nreq_valid,
    input  logic              nreq_ready,
    output logic [2:0]        nreq_type,
    output logic [IDX_W-1:0]  nreq_idx,
    output logic [DATA_W-1:0] nreq_data,
    input  logic              fwd_valid,
    output logic              fwd_ready,
    input  logic [2:0]        fwd_type,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_kind,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              tb_valid,
    input  logic [IDX_W-1:0]  tb_idx,
    input  logic [DATA_W-1:0] tb_data,
    output logic              tb_alloc,
    output logic [IDX_W-1:0]  tb_alloc_idx,
    output logic [DATA_W-1:0] tb_alloc_data,
    output logic              tb_free,
    input  logic              ro_busy,
    output logic              ro_push,
    output logic              ro_req,
    output logic              ro_l2,
    output logic              ro_kind,
    output logic              ro_dirty,
    output logic [DATA_W-1:0] ro_data
);
    import spec_l1_pkg::*;

    typedef struct packed {
        line_state_e       state;
        logic [DATA_W-1:0] line;
        logic              nq_valid;
        logic [2:0]        nq_type;
        logic [IDX_W-1:0]  nq_idx;
        logic [DATA_W-1:0] nq_data;
        logic              dn_valid;
        logic [IDX_W-1:0]  dn_idx;
        logic [DATA_W-1:0] dn_data;
        logic              ev_valid;
        logic              ev_ext;
    } ctl_t;

    ctl_t r_d, r_q;

    logic stable_st, core_fire, fwd_fire, in_m;
    assign stable_st      = !is_transient(r_q.state);
    assign core_req_ready = stable_st && !fwd_valid && !rsp_valid && !r_q.nq_valid;
    assign fwd_ready      = !ro_busy && !rsp_valid;
    assign core_fire      = core_req_valid && core_req_ready;
    assign fwd_fire       = fwd_valid && fwd_ready;
    assign in_m           = (r_q.state == LS_M);

    always_comb begin
        r_d           = r_q;
        r_d.dn_valid  = 1'b0;
        r_d.ev_valid  = 1'b0;
        tb_alloc      = 1'b0;
        tb_alloc_idx  = core_req_idx;
        tb_alloc_data = '0;
        tb_free       = 1'b0;
        ro_push       = 1'b0;
        ro_req        = 1'b0;
        ro_l2         = 1'b0;
        ro_kind       = OUT_DATA;
        ro_dirty      = 1'b0;
        ro_data       = '0;
        if (r_q.nq_valid && nreq_ready) r_d.nq_valid = 1'b0;

        if (rsp_valid) begin
            unique case (r_q.state)
                LS_IS, LS_IS_I, LS_IX: begin
                    r_d.dn_valid = 1'b1;
                    r_d.dn_idx   = tb_idx;
                    r_d.dn_data  = rsp_data;
                    tb_free      = 1'b1;
                    r_d.state    = LS_I;
                    if (r_q.state == LS_IS) begin
                        r_d.line  = rsp_data;
                        r_d.state = (rsp_kind == RK_EXCL) ? LS_E : LS_S;
                    end
                end
                LS_IM, LS_SM: begin
                    r_d.line     = tb_data;
                    r_d.state    = LS_M;
                    r_d.dn_valid = 1'b1;
                    r_d.dn_idx   = tb_idx;
                    r_d.dn_data  = tb_data;
                    tb_free      = 1'b1;
                end
                LS_MI, LS_SINK: begin
                    if (rsp_kind == RK_WBACK) begin
                        r_d.state = LS_I;
                        tb_free   = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (fwd_fire) begin
            ro_push  = 1'b1;
            ro_dirty = in_m || (r_q.state == LS_MI);
            ro_data  = (r_q.state == LS_MI) ? tb_data : r_q.line;
            ro_req   = 1'b1;
            unique case (fwd_type)
                FW_INV: begin
                    ro_kind  = OUT_ACK;
                    ro_dirty = 1'b0;
                    ro_data  = '0;
                    case (r_q.state)
                        LS_IS:  r_d.state = LS_IS_I;
                        LS_S, LS_E: begin
                            r_d.state    = LS_I;
                            r_d.ev_valid = 1'b1;
                            r_d.ev_ext   = 1'b1;
                        end
                        LS_SM: begin
                            r_d.state    = LS_IM;
                            r_d.ev_valid = 1'b1;
                            r_d.ev_ext   = 1'b1;
                        end
                        LS_M: begin
                            ro_req       = 1'b0;
                            ro_l2        = 1'b1;
                            ro_kind      = OUT_DATA;
                            ro_dirty     = 1'b1;
                            ro_data      = r_q.line;
                            r_d.state    = LS_I;
                            r_d.ev_valid = 1'b1;
                            r_d.ev_ext   = 1'b1;
                        end
                        default: ;
                    endcase
                end
                FW_GETS, FW_EXPOSE: begin
                    ro_l2 = 1'b1;
                    if (r_q.state == LS_MI) r_d.state = LS_SINK;
                    else                    r_d.state = LS_S;
                end
                FW_GETX: begin
                    if (r_q.state == LS_MI) r_d.state = LS_SINK;
                    else begin
                        r_d.state    = LS_I;
                        r_d.ev_valid = 1'b1;
                        r_d.ev_ext   = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (core_fire) begin
            unique case (core_req_op)
                OP_LOAD, OP_EXPOSE, OP_SPEC: begin
                    if (r_q.state == LS_NP || r_q.state == LS_I) begin
                        tb_alloc     = 1'b1;
                        r_d.nq_valid = 1'b1;
                        r_d.nq_idx   = core_req_idx;
                        r_d.nq_data  = '0;
                        r_d.nq_type  = (core_req_op == OP_LOAD) ? NQ_GETS :
                                       (core_req_op == OP_SPEC) ? NQ_GETSPEC : NQ_EXPOSE;
                        r_d.state    = (core_req_op == OP_SPEC) ? LS_IX : LS_IS;
                    end else begin
                        r_d.dn_valid = 1'b1;
                        r_d.dn_idx   = core_req_idx;
                        r_d.dn_data  = r_q.line;
                    end
                end
                OP_STORE: begin
                    if (r_q.state == LS_E || in_m) begin
                        r_d.line     = core_req_wdata;
                        r_d.state    = LS_M;
                        r_d.dn_valid = 1'b1;
                        r_d.dn_idx   = core_req_idx;
                        r_d.dn_data  = core_req_wdata;
                    end else begin
                        tb_alloc      = 1'b1;
                        tb_alloc_data = core_req_wdata;
                        r_d.nq_valid  = 1'b1;
                        r_d.nq_type   = NQ_GETX;
                        r_d.nq_idx    = core_req_idx;
                        r_d.nq_data   = '0;
                        r_d.state     = (r_q.state == LS_S) ? LS_SM : LS_IM;
                    end
                end
                OP_REPL: begin
                    if (r_q.state == LS_S || r_q.state == LS_E || in_m) begin
                        r_d.ev_valid = 1'b1;
                        r_d.ev_ext   = 1'b0;
                        r_d.state    = LS_I;
                    end
                    if (in_m) begin
                        tb_alloc      = 1'b1;
                        tb_alloc_data = r_q.line;
                        r_d.nq_valid  = 1'b1;
                        r_d.nq_type   = NQ_PUTX;
                        r_d.nq_idx    = core_req_idx;
                        r_d.nq_data   = r_q.line;
                        r_d.state     = LS_MI;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= LS_NP;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_valid  = r_q.dn_valid;
    assign done_idx    = r_q.dn_idx;
    assign done_data   = r_q.dn_data;
    assign evict_valid = r_q.ev_valid;
    assign evict_ext   = r_q.ev_ext;
    assign nreq_valid  = r_q.nq_valid;
    assign nreq_type   = r_q.nq_type;
    assign nreq_idx    = r_q.nq_idx;
    assign nreq_data   = r_q.nq_data;

    // R1: line starts not present
    p_reset_np_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (r_q.state == LS_NP && !tb_valid));
    // R2: a buffer entry exists exactly while the line is transient
    p_buf_tracks_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tb_valid == is_transient(r_q.state));
    // R3: the speculative-wait state never writes the line
    p_ix_keeps_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == LS_IX) |=> $stable(r_q.line));
    // R3: exclusive data cannot reach the speculative-wait state
    p_ix_no_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && r_q.state == LS_IX) |-> (rsp_kind != RK_EXCL));
    // R9: core held off in transient states
    p_stall_transient_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stable_st |-> !core_req_ready);
    // R12: request held until accepted
    p_nreq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (nreq_valid && !nreq_ready) |=> (nreq_valid && $stable(nreq_type) && $stable(nreq_idx)));
    // R4: invalidation in idle or speculative-wait leaves the state alone
    p_inv_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_fire && fwd_type == FW_INV && !rsp_valid &&
         (r_q.state == LS_NP || r_q.state == LS_I || r_q.state == LS_IX))
        |=> ($stable(r_q.state) && !evict_valid));
endmodule

// File: rtl/spec_l1_line_ctrl.sv
module spec_l1_line_ctrl #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req_valid,
    output logic              core_req_ready,
    input  logic [2:0]        core_req_op,
    input  logic [IDX_W-1:0]  core_req_idx,
    input  logic [DATA_W-1:0] core_req_wdata,
    output logic              done_valid,
    output logic [IDX_W-1:0]  done_idx,
    output logic [DATA_W-1:0] done_data,
    output logic              evict_valid,
    output logic              evict_ext,
    output logic              nreq_valid,
    input  logic              nreq_ready,
    output logic [2:0]        nreq_type,
    output logic [IDX_W-1:0]  nreq_idx,
    output logic [DATA_W-1:0] nreq_data,
    input  logic              fwd_valid,
    output logic              fwd_ready,
    input  logic [2:0]        fwd_type,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_kind,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_dest,
    output logic              out_kind,
    output logic              out_dirty,
    output logic [DATA_W-1:0] out_data
);
    logic              tb_valid, tb_alloc, tb_free;
    logic [IDX_W-1:0]  tb_idx, tb_alloc_idx;
    logic [DATA_W-1:0] tb_data, tb_alloc_data;
    logic              ro_busy, ro_push, ro_req, ro_l2, ro_kind, ro_dirty;
    logic [DATA_W-1:0] ro_data;

    spec_l1_fsm #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
        .core_req_op(core_req_op), .core_req_idx(core_req_idx),
        .core_req_wdata(core_req_wdata),
        .done_valid(done_valid), .done_idx(done_idx), .done_data(done_data),
        .evict_valid(evict_valid), .evict_ext(evict_ext),
        .nreq_valid(nreq_valid), .nreq_ready(nreq_ready), .nreq_type(nreq_type),
        .nreq_idx(nreq_idx), .nreq_data(nreq_data),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_type(fwd_type),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .tb_valid(tb_valid), .tb_idx(tb_idx), .tb_data(tb_data),
        .tb_alloc(tb_alloc), .tb_alloc_idx(tb_alloc_idx),
        .tb_alloc_data(tb_alloc_data), .tb_free(tb_free),
        .ro_busy(ro_busy), .ro_push(ro_push), .ro_req(ro_req), .ro_l2(ro_l2),
        .ro_kind(ro_kind), .ro_dirty(ro_dirty), .ro_data(ro_data)
    );

    spec_l1_tbuf #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_tbuf (
        .clk(clk), .rst_n(rst_n),
        .alloc(tb_alloc), .alloc_idx(tb_alloc_idx), .alloc_data(tb_alloc_data),
        .free(tb_free),
        .tb_valid(tb_valid), .tb_idx(tb_idx), .tb_data(tb_data)
    );

    spec_l1_rsp_out #(.DATA_W(DATA_W)) u_rsp_out (
        .clk(clk), .rst_n(rst_n),
        .push(ro_push), .push_req(ro_req), .push_l2(ro_l2), .push_kind(ro_kind),
        .push_dirty(ro_dirty), .push_data(ro_data),
        .busy(ro_busy),
        .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest),
        .out_kind(out_kind), .out_dirty(out_dirty), .out_data(out_data)
    );
endmodule

// File: tb/spec_l1_line_ctrl_bench.sv
module spec_l1_line_ctrl_bench;
    localparam int IW = 3;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          core_req_valid = 1'b0, core_req_ready;
    logic [2:0]    core_req_op = '0;
    logic [IW-1:0] core_req_idx = '0;
    logic [DW-1:0] core_req_wdata = '0;
    logic          done_valid, evict_valid, evict_ext;
    logic [IW-1:0] done_idx, nreq_idx;
    logic [DW-1:0] done_data, nreq_data, out_data;
    logic          nreq_valid, nreq_ready = 1'b1;
    logic [2:0]    nreq_type;
    logic          fwd_valid = 1'b0, fwd_ready;
    logic [2:0]    fwd_type = '0;
    logic          rsp_valid = 1'b0;
    logic [1:0]    rsp_kind = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          out_valid, out_ready = 1'b1, out_dest, out_kind, out_dirty;

    spec_l1_line_ctrl #(.IDX_W(IW), .DATA_W(DW)) u_spec_l1_line_ctrl (.*);

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [IW+DW-1:0]   q_done[$];
    logic [3+IW+DW-1:0] q_nreq[$];
    logic [3+DW-1:0]    q_out[$];
    logic               q_evict[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as results appear
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && !finished) begin
                if (done_valid) begin
                    if (q_done.size() == 0) chk(0, "done unexpected", {done_idx, done_data}, 0);
                    else begin
                        logic [IW+DW-1:0] e;
                        e = q_done.pop_front();
                        chk({done_idx, done_data} == e, "done R3/R5/R6/R11", {done_idx, done_data}, e);
                    end
                end
                if (nreq_valid && nreq_ready) begin
                    if (q_nreq.size() == 0) chk(0, "nreq unexpected", {nreq_type, nreq_idx, nreq_data}, 0);
                    else begin
                        logic [3+IW+DW-1:0] e;
                        e = q_nreq.pop_front();
                        chk({nreq_type, nreq_idx, nreq_data} == e, "nreq R2/R6/R11",
                            {nreq_type, nreq_idx, nreq_data}, e);
                    end
                end
                if (out_valid && out_ready) begin
                    if (q_out.size() == 0) chk(0, "out unexpected", {out_dest, out_kind, out_dirty, out_data}, 0);
                    else begin
                        logic [3+DW-1:0] e;
                        e = q_out.pop_front();
                        chk({out_dest, out_kind, out_dirty, out_data} == e, "out R4/R7/R8/R14",
                            {out_dest, out_kind, out_dirty, out_data}, e);
                    end
                end
                if (evict_valid) begin
                    if (q_evict.size() == 0) chk(0, "evict unexpected R10", {31'd0, evict_ext}, 0);
                    else begin
                        logic e;
                        e = q_evict.pop_front();
                        chk(evict_ext == e, "evict flag R10", {31'd0, evict_ext}, {31'd0, e});
                    end
                end
            end
        end
    end

    task automatic core_op(input logic [2:0] op, input logic [IW-1:0] idx, input logic [DW-1:0] wd);
        @(negedge clk);
        core_req_valid = 1'b1; core_req_op = op; core_req_idx = idx; core_req_wdata = wd;
        #1;
        while (!core_req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        core_req_valid = 1'b0;
    endtask

    task automatic fwd(input logic [2:0] t);
        @(negedge clk);
        fwd_valid = 1'b1; fwd_type = t;
        #1;
        while (!fwd_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        fwd_valid = 1'b0;
    endtask

    task automatic rsp(input logic [1:0] k, input logic [DW-1:0] d);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_kind = k; rsp_data = d;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic e_done(input logic [IW-1:0] i, input logic [DW-1:0] d); q_done.push_back({i, d}); endtask
    task automatic e_nreq(input logic [2:0] t, input logic [IW-1:0] i, input logic [DW-1:0] d); q_nreq.push_back({t, i, d}); endtask
    task automatic e_out(input logic dst, input logic k, input logic dy, input logic [DW-1:0] d); q_out.push_back({dst, k, dy, d}); endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(core_req_ready && fwd_ready, "R1 ready after reset", {30'd0, core_req_ready, fwd_ready}, 3);
        chk(!done_valid && !evict_valid && !nreq_valid && !out_valid, "R1 outputs idle",
            {28'd0, done_valid, evict_valid, nreq_valid, out_valid}, 0);

        // R4: invalidation in not-present
        e_out(0, 1, 0, 16'h0); fwd(3'd0); settle();

        // R2: speculative miss
        e_nreq(3'd2, 3'd1, 16'h0); core_op(3'd2, 3'd1, 16'h0);
        #1 chk(!core_req_ready, "R9 stall in spec wait", {31'd0, core_req_ready}, 0);
        e_out(0, 1, 0, 16'h0); fwd(3'd0);               // R4 inv in IX
        e_done(3'd1, 16'hA1A1); rsp(2'd0, 16'hA1A1);    // R3 data returns
        settle();

        // R3: line left invalid, load misses
        e_nreq(3'd0, 3'd2, 16'h0); core_op(3'd0, 3'd2, 16'h0);
        e_done(3'd2, 16'hB2B2); rsp(2'd1, 16'hB2B2);    // R11 -> E
        settle();

        // R5: spec hit in E
        e_done(3'd3, 16'hB2B2); core_op(3'd2, 3'd3, 16'h0); settle();
        // R7: forwarded spec get in E
        e_out(0, 0, 0, 16'hB2B2); fwd(3'd3); settle();
        // R11/R5: store still silent (state stayed E)
        e_done(3'd4, 16'hC3C3); core_op(3'd1, 3'd4, 16'hC3C3); settle();
        // R7: spec get in M carries dirty
        e_out(0, 0, 1, 16'hC3C3); fwd(3'd3); settle();
        // R8: forwarded expose in M -> S
        e_out(0, 0, 1, 16'hC3C3); e_out(1, 0, 1, 16'hC3C3); fwd(3'd4); settle();
        // R6: expose hit in S
        e_done(3'd5, 16'hC3C3); core_op(3'd3, 3'd5, 16'h0); settle();

        // R11: store in S -> SM; R10 inv there
        e_nreq(3'd1, 3'd6, 16'h0); core_op(3'd1, 3'd6, 16'hD4D4);
        e_out(0, 1, 0, 16'h0); q_evict.push_back(1'b1); fwd(3'd0);
        e_done(3'd6, 16'hD4D4); rsp(2'd1, 16'h1111); settle();

        // R11: replace M -> writeback; R10 local flag
        e_nreq(3'd4, 3'd0, 16'hD4D4); q_evict.push_back(1'b0); core_op(3'd4, 3'd0, 16'h0);
        e_out(0, 0, 1, 16'hD4D4); fwd(3'd3);             // R7 from buffer
        e_out(0, 0, 1, 16'hD4D4); e_out(1, 0, 1, 16'hD4D4); fwd(3'd4); // R8 in writeback
        settle();
        #1 chk(!core_req_ready, "R9 stall awaiting writeback ack", {31'd0, core_req_ready}, 0);
        rsp(2'd3, 16'h0); settle();
        #1 chk(core_req_ready, "R11 ready after writeback ack", {31'd0, core_req_ready}, 1);

        // R6/R13: expose miss, inv during fill
        e_nreq(3'd3, 3'd7, 16'h0); core_op(3'd3, 3'd7, 16'h0);
        e_out(0, 1, 0, 16'h0); fwd(3'd0);
        e_done(3'd7, 16'hE5E5); rsp(2'd0, 16'hE5E5); settle();
        // R13: line ended invalid, load misses; peer data -> S
        e_nreq(3'd0, 3'd1, 16'h0); core_op(3'd0, 3'd1, 16'h0);
        e_done(3'd1, 16'hF6F6); rsp(2'd2, 16'hF6F6); settle();
        // R10: replace S, local flag, no request
        q_evict.push_back(1'b0); core_op(3'd4, 3'd2, 16'h0); settle();
        e_nreq(3'd0, 3'd3, 16'h0); core_op(3'd0, 3'd3, 16'h0);
        e_done(3'd3, 16'h7777); rsp(2'd1, 16'h7777); settle();
        // R14/R10: forwarded GETX in E
        e_out(0, 0, 0, 16'h7777); q_evict.push_back(1'b1); fwd(3'd2); settle();

        // R12: request held under back-pressure
        nreq_ready = 1'b0;
        e_nreq(3'd0, 3'd5, 16'h0); core_op(3'd0, 3'd5, 16'h0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(nreq_valid && nreq_type == 3'd0 && nreq_idx == 3'd5, "R12 nreq held",
                {25'd0, nreq_valid, nreq_type, nreq_idx}, {25'd0, 1'b1, 3'd0, 3'd5});
        end
        @(negedge clk); nreq_ready = 1'b1;
        settle();
        e_done(3'd5, 16'h8888); rsp(2'd1, 16'h8888); settle();
        // R12/R14: forwarded GETS under output back-pressure
        out_ready = 1'b0;
        e_out(0, 0, 0, 16'h8888); e_out(1, 0, 0, 16'h8888); fwd(3'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(out_valid && out_dest == 1'b0 && out_data == 16'h8888, "R12 out held",
                {15'd0, out_valid, out_dest, out_data}, {15'd0, 1'b1, 1'b0, 16'h8888});
        end
        @(negedge clk); out_ready = 1'b1;
        settle();
        // R14: now S; store -> M, inv in M returns dirty data to L2
        e_nreq(3'd1, 3'd2, 16'h0); core_op(3'd1, 3'd2, 16'h9999);
        e_done(3'd2, 16'h9999); rsp(2'd0, 16'h0); settle();
        e_out(1, 0, 1, 16'h9999); q_evict.push_back(1'b1); fwd(3'd0); settle();
        // R4: invalidation in invalid
        e_out(0, 1, 0, 16'h0); fwd(3'd0); settle();

        chk(q_done.size() == 0 && q_nreq.size() == 0 && q_out.size() == 0 && q_evict.size() == 0,
            "R3/R11 all expected results seen",
            q_done.size() + q_nreq.size() + q_out.size() + q_evict.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule